// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces every raster timing signal that a character-based video pipeline needs, starting from one master clock. Two free-running dividers turn the master clock into a pixel-rate enable (one pulse every four cycles) and a CPU bus-rate enable (one pulse every fourteen cycles). Because 14 is not a multiple of 4, the two dividers are separate counters, and they meet again only every 28 cycles.

Driven by the pixel enable, a horizontal counter walks 228 pixel periods per scanline, and a vertical counter walks either 262 or 312 scanlines per frame. A geometry-select input picks the frame length. From the two counters the block decodes horizontal and vertical sync, blanking and an active-display flag. Inside the active window it also gives the cell coordinates that a later fetch and render stage uses: character column, character row, pixel within the cell and line within the cell. The geometry select is sampled only when a frame begins, so a frame is never cut short or lengthened partway through.

All outputs change only on master clock edges. They are meaningful in the cycle where `pix_en` is high. The reset input is asynchronous and active low. Internally its release is synchronised to the master clock.

Top module: `vtg_top`

## Requirements
- R1: `pix_en` is high for exactly one master cycle out of every PIX_DIV (default 4). After reset release, its first pulse marks pixel 0 of line 0.
- R2: `bus_en` is high for exactly one master cycle out of every BUS_DIV (default 14). It comes from its own counter, and its first pulse after reset release falls in the same cycle as the first `pix_en`.
- R3: A scanline lasts LINE_PIX (default 228) pixel enables. `line_start` is high only in the `pix_en` cycle of pixel 0 of each line.
- R4: `active` is high exactly when the horizontal position is in [24, 24+COLS*CELL_W) = [24, 200) and the line is in [V_START, V_START+ACT_LINES) (defaults 28 and 184). `blank` is the inverse of `active`.
- R5: `hsync` is high for pixels [208, 224): 16 periods that start 8 periods after the active window ends. `vsync` is high for VS_LEN (default 3) whole lines that start VS_GAP (default 4) lines after the last active line.
- R6: A frame lasts LINES_60HZ (default 262) lines when the sampled geometry is 0, and LINES_50HZ (default 312) lines when it is 1. `frame_start` is high only in the `pix_en` cycle of pixel 0 of line 0, and `line_start` is always high with it.
- R7: Inside the active window, `char_col` = (h-24)/8, `cell_px` = (h-24) mod 8, `char_row` = (v-V_START)/8 and `cell_line` = (v-V_START) mod 8. Outside the window all four are 0.
- R8: `geom_sel` is sampled only in the `frame_start` cycle. A change at any other time has no effect until the next frame begins.
- R9: While reset is asserted, `pix_en`, `bus_en`, `line_start` and `frame_start` are low. Reset asserted in the middle of a frame restarts both dividers and both counters from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| geom_sel | input | 1 | Frame geometry: 0 = 60 Hz line count, 1 = 50 Hz line count |
| pix_en | output | 1 | Pixel-rate clock enable |
| bus_en | output | 1 | Bus-rate clock enable |
| line_start | output | 1 | Pixel 0 of a line, aligned with `pix_en` |
| frame_start | output | 1 | Pixel 0 of line 0, aligned with `pix_en` |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the active window |
| active | output | 1 | High inside the active window |
| char_col | output | 5 | Character column in the active window |
| char_row | output | 5 | Character row in the active window |
| cell_px | output | 3 | Pixel index within the cell |
| cell_line | output | 3 | Line index within the cell |

## Verification
The bench rebuilds the expected raster position from its own count of master cycles and checks every output at every pixel enable over whole frames. It uses full-width lines but a reduced line count. It goes after these corner cases:
- Edges of the active window and of the sync windows: an off-by-one compare there would shift blanking or sync by one pixel or one line.
- Frames of both lengths, with the geometry input toggled in mid-frame: a design that applied the new value at once would end the current frame at the wrong line.
- Phase of the bus enable against the pixel enable: if the two dividers were shared or chained, the bus enable would no longer fall every 14 cycles.
- Reset asserted in mid-frame: if a counter were left uncleared, the first pulse after the reset would not carry `frame_start`.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Frame geometry selector values.
  typedef enum logic {
    GEOM_60 = 1'b0,
    GEOM_50 = 1'b1
  } geom_e;

  // Width of a counter that holds 0..n-1, never less than one bit.
  function automatic int cw(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vtg_rst_sync.sv
module vtg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  // Assert at once, release after two clean edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/vtg_clk_div.sv
module vtg_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = vtg_pkg::cw(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Gated by reset so no pulse leaks while the block is held.
  assign tick = rst_n && (cnt_q == '0);

  // Independent spacing monitor for the enable output.
  generate
    if (DIV > 1) begin : g_spacing_chk
      logic [CW-1:0] gap_q;
      logic          seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gap_q  <= '0;
          seen_q <= 1'b0;
        end else if (tick) begin
          gap_q  <= '0;
          seen_q <= 1'b1;
        end else begin
          gap_q  <= gap_q + 1'b1;
        end
      end

      // R1 / R2: pulses are exactly DIV cycles apart
      p_tick_spacing_r1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |-> (gap_q == LAST));

      // R1 / R2: a pulse is a single cycle wide
      p_tick_single_r1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
  parameter int LINE_PIX   = 228,
  parameter int LINES_60HZ = 262,
  parameter int LINES_50HZ = 312,
  localparam int HW = vtg_pkg::cw(LINE_PIX),
  localparam int VW = vtg_pkg::cw(vtg_pkg::imax(LINES_60HZ, LINES_50HZ))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  vtg_pkg::geom_e  geom_in,
  output logic [HW-1:0]   h_pos,
  output logic [VW-1:0]   v_pos,
  output logic            sol,
  output logic            sof
);

  import vtg_pkg::*;

  localparam logic [HW-1:0] H_LAST   = HW'(LINE_PIX - 1);
  localparam logic [VW-1:0] V_LAST60 = VW'(LINES_60HZ - 1);
  localparam logic [VW-1:0] V_LAST50 = VW'(LINES_50HZ - 1);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  geom_e         geom_q, geom_d;
  logic          h_last, v_last;

  assign h_last = (h_q == H_LAST);
  assign v_last = (geom_q == GEOM_50) ? (v_q == V_LAST50) : (v_q == V_LAST60);

  assign sol = pix_en && (h_q == '0);
  assign sof = sol && (v_q == '0);

  always_comb begin
    h_d    = h_q;
    v_d    = v_q;
    geom_d = geom_q;
    if (sof) geom_d = geom_in;
    if (pix_en) begin
      if (h_last) begin
        h_d = '0;
        if (v_last) v_d = '0;
        else        v_d = v_q + 1'b1;
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      v_q    <= '0;
      geom_q <= GEOM_60;
    end else begin
      h_q    <= h_d;
      v_q    <= v_d;
      geom_q <= geom_d;
    end
  end

  assign h_pos = h_q;
  assign v_pos = v_q;

  // R3: horizontal counter wraps to pixel 0 after the last pixel
  p_hwrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && (h_q == H_LAST)) |=> (h_q == '0));

  // R3: position holds between pixel enables
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(h_q) && $stable(v_q)));

  // R6: frame ends on the line count of the sampled geometry
  p_frame_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && h_last && (geom_q == GEOM_60) && (v_q == V_LAST60)) |=> (v_q == '0));

  // R8: sampled geometry only changes just after a frame start
  p_geom_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(geom_q) |-> $past(sof));

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
  parameter int HW        = 8,
  parameter int VW        = 9,
  parameter int H_START   = 24,
  parameter int COLS      = 22,
  parameter int CELL_W    = 8,
  parameter int CELL_H    = 8,
  parameter int HS_GAP    = 8,
  parameter int HS_LEN    = 16,
  parameter int V_START   = 28,
  parameter int ACT_LINES = 184,
  parameter int VS_GAP    = 4,
  parameter int VS_LEN    = 3,
  localparam int COL_W = vtg_pkg::cw(COLS),
  localparam int ROW_W = vtg_pkg::cw(ACT_LINES / CELL_H),
  localparam int PX_W  = vtg_pkg::cw(CELL_W),
  localparam int LN_W  = vtg_pkg::cw(CELL_H)
) (
  input  logic [HW-1:0]    h_pos,
  input  logic [VW-1:0]    v_pos,
  output logic             hsync,
  output logic             vsync,
  output logic             active,
  output logic [COL_W-1:0] char_col,
  output logic [ROW_W-1:0] char_row,
  output logic [PX_W-1:0]  cell_px,
  output logic [LN_W-1:0]  cell_line
);

  localparam int H_END  = H_START + COLS * CELL_W;
  localparam int HS_BEG = H_END + HS_GAP;
  localparam int V_END  = V_START + ACT_LINES;
  localparam int VS_BEG = V_END + VS_GAP;

  localparam logic [HW-1:0] H_ST  = HW'(H_START);
  localparam logic [HW-1:0] H_EN  = HW'(H_END);
  localparam logic [HW-1:0] HS_B  = HW'(HS_BEG);
  localparam logic [HW-1:0] HS_E  = HW'(HS_BEG + HS_LEN);
  localparam logic [VW-1:0] V_ST  = VW'(V_START);
  localparam logic [VW-1:0] V_EN  = VW'(V_END);
  localparam logic [VW-1:0] VS_B  = VW'(VS_BEG);
  localparam logic [VW-1:0] VS_E  = VW'(VS_BEG + VS_LEN);

  logic          h_act, v_act;
  logic [HW-1:0] h_off;
  logic [VW-1:0] v_off;

  always_comb begin
    h_act  = (h_pos >= H_ST) && (h_pos < H_EN);
    v_act  = (v_pos >= V_ST) && (v_pos < V_EN);
    active = h_act && v_act;
    hsync  = (h_pos >= HS_B) && (h_pos < HS_E);
    vsync  = (v_pos >= VS_B) && (v_pos < VS_E);
    h_off  = h_pos - H_ST;
    v_off  = v_pos - V_ST;
    if (active) begin
      char_col  = COL_W'(h_off / HW'(CELL_W));
      cell_px   = PX_W'(h_off % HW'(CELL_W));
      char_row  = ROW_W'(v_off / VW'(CELL_H));
      cell_line = LN_W'(v_off % VW'(CELL_H));
    end else begin
      char_col  = '0;
      cell_px   = '0;
      char_row  = '0;
      cell_line = '0;
    end
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter int PIX_DIV    = 4,
  parameter int BUS_DIV    = 14,
  parameter int LINE_PIX   = 228,
  parameter int H_START    = 24,
  parameter int COLS       = 22,
  parameter int CELL_W     = 8,
  parameter int CELL_H     = 8,
  parameter int HS_GAP     = 8,
  parameter int HS_LEN     = 16,
  parameter int LINES_60HZ = 262,
  parameter int LINES_50HZ = 312,
  parameter int V_START    = 28,
  parameter int ACT_LINES  = 184,
  parameter int VS_GAP     = 4,
  parameter int VS_LEN     = 3,
  localparam int COL_W = vtg_pkg::cw(COLS),
  localparam int ROW_W = vtg_pkg::cw(ACT_LINES / CELL_H),
  localparam int PX_W  = vtg_pkg::cw(CELL_W),
  localparam int LN_W  = vtg_pkg::cw(CELL_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             geom_sel,
  output logic             pix_en,
  output logic             bus_en,
  output logic             line_start,
  output logic             frame_start,
  output logic             hsync,
  output logic             vsync,
  output logic             blank,
  output logic             active,
  output logic [COL_W-1:0] char_col,
  output logic [ROW_W-1:0] char_row,
  output logic [PX_W-1:0]  cell_px,
  output logic [LN_W-1:0]  cell_line
);

  localparam int HW = vtg_pkg::cw(LINE_PIX);
  localparam int VW = vtg_pkg::cw(vtg_pkg::imax(LINES_60HZ, LINES_50HZ));

  logic          srst_n;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;

  vtg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vtg_clk_div #(.DIV(PIX_DIV)) u_pix_div (
    .clk   (clk),
    .rst_n (srst_n),
    .tick  (pix_en)
  );

  vtg_clk_div #(.DIV(BUS_DIV)) u_bus_div (
    .clk   (clk),
    .rst_n (srst_n),
    .tick  (bus_en)
  );

  vtg_raster #(
    .LINE_PIX   (LINE_PIX),
    .LINES_60HZ (LINES_60HZ),
    .LINES_50HZ (LINES_50HZ)
  ) u_raster (
    .clk     (clk),
    .rst_n   (srst_n),
    .pix_en  (pix_en),
    .geom_in (vtg_pkg::geom_e'(geom_sel)),
    .h_pos   (h_pos),
    .v_pos   (v_pos),
    .sol     (line_start),
    .sof     (frame_start)
  );

  vtg_decode #(
    .HW        (HW),
    .VW        (VW),
    .H_START   (H_START),
    .COLS      (COLS),
    .CELL_W    (CELL_W),
    .CELL_H    (CELL_H),
    .HS_GAP    (HS_GAP),
    .HS_LEN    (HS_LEN),
    .V_START   (V_START),
    .ACT_LINES (ACT_LINES),
    .VS_GAP    (VS_GAP),
    .VS_LEN    (VS_LEN)
  ) u_decode (
    .h_pos     (h_pos),
    .v_pos     (v_pos),
    .hsync     (hsync),
    .vsync     (vsync),
    .active    (active),
    .char_col  (char_col),
    .char_row  (char_row),
    .cell_px   (cell_px),
    .cell_line (cell_line)
  );

  assign blank = !active;

  // R5: sync pulses lie inside blanking
  p_sync_in_blank_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (hsync || vsync) |-> blank);

  // R7: cell coordinates rest at zero outside the window
  p_idle_coords_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !active |-> ((char_col == '0) && (cell_px == '0) && (char_row == '0) && (cell_line == '0)));

  // R7: column index stays inside the window width
  p_col_bound_r7: assert property (@(posedge clk) disable iff (!srst_n)
    active |-> (char_col < COL_W'(COLS)));

  // R6 / R9: frame strobe coincides with a line strobe and a pixel enable
  p_sof_aligned_r6: assert property (@(posedge clk) disable iff (!srst_n)
    frame_start |-> (pix_en && line_start));

  // R3: line strobe only with a pixel enable
  p_sol_aligned_r3: assert property (@(posedge clk) disable iff (!srst_n)
    line_start |-> pix_en);

endmodule

// File: tb/tb_vtg_top.sv
module tb_vtg_top;

  // Reduced line count, full-width lines.
  localparam int LINE_PIX = 228;
  localparam int H_ST     = 24;
  localparam int H_EN     = 200;
  localparam int HS_B     = 208;
  localparam int HS_E     = 224;
  localparam int LINES_A  = 40;
  localparam int LINES_B  = 48;
  localparam int V_ST     = 6;
  localparam int ACT_LN   = 24;
  localparam int VS_B     = V_ST + ACT_LN + 2;
  localparam int VS_E     = VS_B + 3;
  localparam int COL_W    = vtg_pkg::cw(22);
  localparam int ROW_W    = vtg_pkg::cw(ACT_LN / 8);

  logic clk, rst_n, geom_sel;
  logic pix_en, bus_en, line_start, frame_start, hsync, vsync, blank, active;
  logic [COL_W-1:0] char_col;
  logic [ROW_W-1:0] char_row;
  logic [2:0] cell_px, cell_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vtg_top #(
    .LINES_60HZ (LINES_A),
    .LINES_50HZ (LINES_B),
    .V_START    (V_ST),
    .ACT_LINES  (ACT_LN),
    .VS_GAP     (2),
    .VS_LEN     (3)
  ) dut (
    .clk (clk), .rst_n (rst_n), .geom_sel (geom_sel),
    .pix_en (pix_en), .bus_en (bus_en), .line_start (line_start),
    .frame_start (frame_start), .hsync (hsync), .vsync (vsync),
    .blank (blank), .active (active), .char_col (char_col),
    .char_row (char_row), .cell_px (cell_px), .cell_line (cell_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R9 pix_en"}, pix_en, 0);
    chk({tag, " R9 bus_en"}, bus_en, 0);
    chk({tag, " R9 line_start"}, line_start, 0);
    chk({tag, " R9 frame_start"}, frame_start, 0);
  endtask

  // Release reset and wait for the first pixel enable; check it opens a frame.
  task automatic release_and_sync();
    int wait_n;
    @(negedge clk);
    rst_n = 1'b1;
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!pix_en && wait_n < 8);
    chk("R1 first pix_en arrives", int'(pix_en), 1);
    chk("R9 first pulse is frame start", int'(frame_start), 1);
    chk("R3 first pulse is line start", int'(line_start), 1);
    chk("R2 bus_en with first pix_en", int'(bus_en), 1);
  endtask

  initial begin
    int h, v, c, frame_idx, cur_lines;
    bit exp_act;
    rst_n    = 1'b0;
    geom_sel = 1'b0;
    repeat (4) @(negedge clk);
    chk_idle("reset");
    chk("R4 blank in reset", int'(blank), 1);

    release_and_sync();

    h = 0; v = 0; c = 0; frame_idx = -1; cur_lines = LINES_A;
    while (frame_idx < 3) begin
      if (c != 0) @(negedge clk);
      chk("R1 pix_en cadence", int'(pix_en), int'(c % 4 == 0));
      chk("R2 bus_en cadence", int'(bus_en), int'(c % 14 == 0));
      if (c % 4 == 0) begin
        if (h == 0 && v == 0) begin
          frame_idx++;
          cur_lines = geom_sel ? LINES_B : LINES_A;
        end
        if (frame_idx < 3) begin
          exp_act = (h >= H_ST) && (h < H_EN) && (v >= V_ST) && (v < V_ST + ACT_LN);
          chk("R3 line_start", int'(line_start), int'(h == 0));
          chk("R6 frame_start", int'(frame_start), int'(h == 0 && v == 0));
          chk("R4 active", int'(active), int'(exp_act));
          chk("R4 blank", int'(blank), int'(!exp_act));
          chk("R5 hsync", int'(hsync), int'(h >= HS_B && h < HS_E));
          chk("R5 vsync", int'(vsync), int'(v >= VS_B && v < VS_E));
          chk("R7 char_col", int'(char_col), exp_act ? (h - H_ST) / 8 : 0);
          chk("R7 cell_px", int'(cell_px), exp_act ? (h - H_ST) % 8 : 0);
          chk("R7 char_row", int'(char_row), exp_act ? (v - V_ST) / 8 : 0);
          chk("R7 cell_line", int'(cell_line), exp_act ? (v - V_ST) % 8 : 0);
          // R8: flip geometry in mid-frame; must wait for next frame start
          if (h == 100 && v == 10) geom_sel = (frame_idx == 0);
          h++;
          if (h == LINE_PIX) begin
            h = 0;
            v++;
            if (v == cur_lines) v = 0;
          end
        end
      end else begin
        chk("R3 line_start between enables", int'(line_start), 0);
        chk("R6 frame_start between enables", int'(frame_start), 0);
      end
      c++;
    end

    // R9: reset in mid-frame restarts everything.
    repeat (1000) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("mid-frame reset");
    release_and_sync();
    chk("R7 idle coords after restart", int'(char_col), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule